// File: doc/BRIEF.md
# Pipeline Bypass and Load-Use Interlock Control

This block is the hazard-control logic of an in-order five-stage integer pipeline with fetch, decode, execute, memory and writeback stages. It holds no state. It takes the instruction sitting in decode and the register numbers, write-enables and load and store flags carried by the three later pipeline registers. From these it produces the operand multiplexer selects for the execute stage and a select that steers loaded data into a store's memory write. It also produces a pair of signals that freeze fetch and inject a bubble when a load's result is needed by the very next instruction's ALU.

Decode reads the register file and writeback writes it, so the only hazard that can occur is a read after write. A result sitting in a later pipeline register is routed back to whichever execute operand names it. A register written in writeback is passed straight to a read of that register in decode. A load whose value is wanted only as the data of the following store does not cost a cycle: the value is substituted in the memory stage, one cycle after the load leaves it.

The block also extracts the decode instruction's destination field according to its format. The same pipeline registers that this block later reads carry that destination forward.

Top module: `hazard_ctrl`

## Requirements
- R1: Decode kind codes are 0 none, 1 register-register, 2 register-immediate, 3 load, 4 store, 5 branch, and 6 and 7 are treated as none. Sources are instruction bits 25:21 (A) and 20:16 (B). `dec_dst` is bits 15:11 for kind 1 and bits 20:16 for kinds 2 and 3, each with `dec_wen`=1. Every other kind gives `dec_dst`=0 and `dec_wen`=0.
- R2: Select code 1 on `fwd_a_sel` or `fwd_b_sel` picks the EX/MEM result. It is chosen when EX/MEM writes a non-load result to the execute operand's register. Code 3 never appears.
- R3: Select code 2 picks the MEM/WB value, whether that value is an ALU result or a load result. It is chosen when MEM/WB writes the operand's register and code 1 does not apply. Code 0 means the register-file value.
- R4: When EX/MEM and MEM/WB both write the operand's register, code 1 wins.
- R5: Register 0 never causes a forward, a decode bypass, a store-data forward or a stall.
- R6: A producer whose write-enable is clear never matches. This covers stores and branches.
- R7: A load sitting in EX/MEM is never forwarded by code 1, because that stage holds its address. The select falls through to MEM/WB or to the register file.
- R8: `hold_fetch` and `insert_bubble` are both 1 exactly when ID/EX holds a writing load to a nonzero register that the decode instruction uses as an ALU operand. Source A is an ALU operand for kinds 1 to 5, and source B is one for kinds 1 and 5.
- R9: A store in decode whose data register (source B) is the destination of the load in ID/EX does not stall.
- R10: `store_data_fwd` is 1 when EX/MEM holds a store and MEM/WB holds a writing load to the store's data register. A non-load producer in MEM/WB does not set it.
- R11: `dec_rf_byp_a` and `dec_rf_byp_b` are 1 when MEM/WB writes a nonzero register that the decode instruction reads through that source. Source B is read by kinds 1, 4 and 5 only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dec_instr | input | 32 | Instruction word held in decode |
| dec_kind | input | 3 | Format/kind code of the decode instruction |
| ex_src_a | input | 5 | ID/EX source A register |
| ex_src_b | input | 5 | ID/EX source B register |
| ex_dst | input | 5 | ID/EX destination register |
| ex_wen | input | 1 | ID/EX writes a register |
| ex_load | input | 1 | ID/EX instruction is a load |
| mem_dst | input | 5 | EX/MEM destination register |
| mem_wen | input | 1 | EX/MEM writes a register |
| mem_load | input | 1 | EX/MEM instruction is a load |
| mem_store | input | 1 | EX/MEM instruction is a store |
| mem_store_src | input | 5 | EX/MEM store data register |
| wb_dst | input | 5 | MEM/WB destination register |
| wb_wen | input | 1 | MEM/WB writes a register |
| wb_load | input | 1 | MEM/WB instruction is a load |
| fwd_a_sel | output | 2 | Execute operand A select (0 file, 1 EX/MEM, 2 MEM/WB) |
| fwd_b_sel | output | 2 | Execute operand B select, same codes |
| store_data_fwd | output | 1 | Replace memory write data with MEM/WB load data |
| dec_rf_byp_a | output | 1 | Decode read A takes the writeback value |
| dec_rf_byp_b | output | 1 | Decode read B takes the writeback value |
| dec_dst | output | 5 | Destination register of the decode instruction |
| dec_wen | output | 1 | Decode instruction writes a register |
| hold_fetch | output | 1 | Hold PC and IF/ID this cycle |
| insert_bubble | output | 1 | Zero control bits entering ID/EX this cycle |

## Verification
The block has no state, so any fault appears at the ports in the same cycle as the stimulus that exposes it. A wrong comparison or priority gives a select code that differs from the one the requirements predict for that combination of pipeline registers. A missing or extra interlock shows on the hold and bubble pair. The stimulus places the same register in several stages at once, uses register 0, and clears the write-enables. It also puts loads into each stage so that forwarding, the decode bypass and stalling are each shown to hinge on the right flag.

// File: rtl/hz_pkg.sv
package hz_pkg;

    localparam int INSTR_W     = 32;
    localparam int REG_W       = 5;
    localparam int SRC_A_LSB   = 21;
    localparam int SRC_B_LSB   = 16;
    localparam int DST_RR_LSB  = 11;
    localparam int NUM_ALU_OPS = 2;

    typedef logic [REG_W-1:0]   reg_idx_t;
    typedef logic [INSTR_W-1:0] instr_t;

    typedef enum logic [2:0] {
        K_NONE   = 3'd0,
        K_RR     = 3'd1,
        K_RI     = 3'd2,
        K_LOAD   = 3'd3,
        K_STORE  = 3'd4,
        K_BRANCH = 3'd5
    } op_kind_e;

    typedef enum logic [1:0] {
        FWD_RF  = 2'd0,
        FWD_MEM = 2'd1,
        FWD_WB  = 2'd2
    } fwd_sel_e;

    // A later pipeline register seen as a possible result source
    typedef struct packed {
        reg_idx_t dst;
        logic     wen;
        logic     is_load;
    } producer_t;

    // What the decode instruction reads and writes
    typedef struct packed {
        reg_idx_t src_a;
        reg_idx_t src_b;
        logic     use_a;
        logic     alu_b;
        logic     data_b;
        reg_idx_t dst;
        logic     wen;
    } dec_info_t;

    function automatic reg_idx_t field_at(instr_t w, int lsb);
        return w[lsb +: REG_W];
    endfunction

    // Producer writes src, and src is not the hard-wired zero register
    function automatic logic hits(reg_idx_t src, producer_t p);
        return p.wen && (p.dst != '0) && (p.dst == src);
    endfunction

endpackage

// File: rtl/hz_src_decode.sv
module hz_src_decode
    import hz_pkg::*;
(
    input  instr_t    instr_i,
    input  logic [2:0] kind_i,
    output dec_info_t info_o
);

    op_kind_e kind;
    assign kind = op_kind_e'(kind_i);

    always_comb begin
        info_o        = '0;
        info_o.src_a  = field_at(instr_i, SRC_A_LSB);
        info_o.src_b  = field_at(instr_i, SRC_B_LSB);
        case (kind)
            K_RR: begin
                info_o.use_a = 1'b1;
                info_o.alu_b = 1'b1;
                info_o.dst   = field_at(instr_i, DST_RR_LSB);
                info_o.wen   = 1'b1;
            end
            K_RI, K_LOAD: begin
                info_o.use_a = 1'b1;
                info_o.dst   = field_at(instr_i, SRC_B_LSB);
                info_o.wen   = 1'b1;
            end
            K_STORE: begin
                info_o.use_a  = 1'b1;
                info_o.data_b = 1'b1;
            end
            K_BRANCH: begin
                info_o.use_a = 1'b1;
                info_o.alu_b = 1'b1;
            end
            default: begin
                info_o.use_a = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/hz_fwd_select.sv
module hz_fwd_select
    import hz_pkg::*;
(
    input  reg_idx_t  src_i,
    input  producer_t mem_i,
    input  producer_t wb_i,
    output fwd_sel_e  sel_o
);

    // EX/MEM of a load carries an address, so it is not a result source
    logic mem_hit;
    logic wb_hit;

    assign mem_hit = hits(src_i, mem_i) && !mem_i.is_load;
    assign wb_hit  = hits(src_i, wb_i);

    always_comb begin
        if (mem_hit)
            sel_o = FWD_MEM;
        else if (wb_hit)
            sel_o = FWD_WB;
        else
            sel_o = FWD_RF;
    end

endmodule

// File: rtl/hz_stall_detect.sv
module hz_stall_detect
    import hz_pkg::*;
(
    input  dec_info_t dec_i,
    input  producer_t ex_i,
    output logic      stall_o
);

    logic need_a;
    logic need_b;

    assign need_a  = dec_i.use_a && hits(dec_i.src_a, ex_i);
    assign need_b  = dec_i.alu_b && hits(dec_i.src_b, ex_i);
    assign stall_o = ex_i.is_load && (need_a || need_b);

endmodule

// File: rtl/hz_late_bypass.sv
module hz_late_bypass
    import hz_pkg::*;
(
    input  dec_info_t dec_i,
    input  logic      mem_store_i,
    input  reg_idx_t  mem_store_src_i,
    input  producer_t wb_i,
    output logic      dec_byp_a_o,
    output logic      dec_byp_b_o,
    output logic      store_fwd_o
);

    assign dec_byp_a_o = dec_i.use_a && hits(dec_i.src_a, wb_i);
    assign dec_byp_b_o = (dec_i.alu_b || dec_i.data_b) && hits(dec_i.src_b, wb_i);
    assign store_fwd_o = mem_store_i && wb_i.is_load && hits(mem_store_src_i, wb_i);

endmodule

// File: rtl/hazard_ctrl.sv
module hazard_ctrl
    import hz_pkg::*;
(
    input  logic [31:0] dec_instr,
    input  logic [2:0]  dec_kind,
    input  logic [4:0]  ex_src_a,
    input  logic [4:0]  ex_src_b,
    input  logic [4:0]  ex_dst,
    input  logic        ex_wen,
    input  logic        ex_load,
    input  logic [4:0]  mem_dst,
    input  logic        mem_wen,
    input  logic        mem_load,
    input  logic        mem_store,
    input  logic [4:0]  mem_store_src,
    input  logic [4:0]  wb_dst,
    input  logic        wb_wen,
    input  logic        wb_load,
    output logic [1:0]  fwd_a_sel,
    output logic [1:0]  fwd_b_sel,
    output logic        store_data_fwd,
    output logic        dec_rf_byp_a,
    output logic        dec_rf_byp_b,
    output logic [4:0]  dec_dst,
    output logic        dec_wen,
    output logic        hold_fetch,
    output logic        insert_bubble
);

    dec_info_t dec_info;
    producer_t p_ex;
    producer_t p_mem;
    producer_t p_wb;
    logic      stall;
    reg_idx_t  ex_src [NUM_ALU_OPS];
    fwd_sel_e  op_sel [NUM_ALU_OPS];

    assign p_ex  = '{dst: ex_dst,  wen: ex_wen,  is_load: ex_load};
    assign p_mem = '{dst: mem_dst, wen: mem_wen, is_load: mem_load};
    assign p_wb  = '{dst: wb_dst,  wen: wb_wen,  is_load: wb_load};

    assign ex_src[0] = ex_src_a;
    assign ex_src[1] = ex_src_b;

    hz_src_decode u_decode (
        .instr_i (dec_instr),
        .kind_i  (dec_kind),
        .info_o  (dec_info)
    );

    for (genvar g = 0; g < NUM_ALU_OPS; g++) begin : g_operand
        hz_fwd_select u_sel (
            .src_i (ex_src[g]),
            .mem_i (p_mem),
            .wb_i  (p_wb),
            .sel_o (op_sel[g])
        );
    end

    hz_stall_detect u_stall (
        .dec_i   (dec_info),
        .ex_i    (p_ex),
        .stall_o (stall)
    );

    hz_late_bypass u_late (
        .dec_i           (dec_info),
        .mem_store_i     (mem_store),
        .mem_store_src_i (mem_store_src),
        .wb_i            (p_wb),
        .dec_byp_a_o     (dec_rf_byp_a),
        .dec_byp_b_o     (dec_rf_byp_b),
        .store_fwd_o     (store_data_fwd)
    );

    assign fwd_a_sel     = op_sel[0];
    assign fwd_b_sel     = op_sel[1];
    assign dec_dst       = dec_info.dst;
    assign dec_wen       = dec_info.wen;
    assign hold_fetch    = stall;
    assign insert_bubble = stall;

endmodule

// File: rtl/hazard_ctrl_chk.sv
module hazard_ctrl_chk (
    input logic [2:0] dec_kind,
    input logic [4:0] ex_src_a,
    input logic [4:0] ex_src_b,
    input logic [4:0] ex_dst,
    input logic       ex_wen,
    input logic       ex_load,
    input logic [4:0] mem_dst,
    input logic       mem_wen,
    input logic       mem_load,
    input logic       mem_store,
    input logic       wb_wen,
    input logic       wb_load,
    input logic [1:0] fwd_a_sel,
    input logic [1:0] fwd_b_sel,
    input logic       store_data_fwd,
    input logic       dec_wen,
    input logic       hold_fetch,
    input logic       insert_bubble
);

    always_comb begin
        AST_HOLD_PAIRS_BUBBLE: assert (hold_fetch == insert_bubble); // R8
        if (hold_fetch)
            AST_STALL_NEEDS_LOAD: assert (ex_load && ex_wen && ex_dst != 5'd0); // R8
        AST_SEL_CODE_LEGAL: assert (fwd_a_sel != 2'd3 && fwd_b_sel != 2'd3); // R2
        if (ex_src_a == 5'd0)
            AST_ZERO_REG_A_RF: assert (fwd_a_sel == 2'd0); // R5
        if (ex_src_b == 5'd0)
            AST_ZERO_REG_B_RF: assert (fwd_b_sel == 2'd0); // R5
        if (mem_load)
            AST_NO_ADDR_FORWARD: assert (fwd_a_sel != 2'd1 && fwd_b_sel != 2'd1); // R7
        if (fwd_a_sel == 2'd1)
            AST_MEM_SRC_WRITES: assert (mem_wen && mem_dst == ex_src_a); // R6
        if (fwd_a_sel == 2'd2)
            AST_WB_ONLY_WITHOUT_MEM: assert (!(mem_wen && !mem_load && mem_dst == ex_src_a)); // R4
        if (store_data_fwd)
            AST_STFWD_LOAD_TO_STORE: assert (mem_store && wb_load && wb_wen); // R10
        if (dec_kind == 3'd4 || dec_kind == 3'd5)
            AST_NO_DST_STORE_BRANCH: assert (!dec_wen); // R1
    end

endmodule

bind hazard_ctrl hazard_ctrl_chk u_chk (
    .dec_kind       (dec_kind),
    .ex_src_a       (ex_src_a),
    .ex_src_b       (ex_src_b),
    .ex_dst         (ex_dst),
    .ex_wen         (ex_wen),
    .ex_load        (ex_load),
    .mem_dst        (mem_dst),
    .mem_wen        (mem_wen),
    .mem_load       (mem_load),
    .mem_store      (mem_store),
    .wb_wen         (wb_wen),
    .wb_load        (wb_load),
    .fwd_a_sel      (fwd_a_sel),
    .fwd_b_sel      (fwd_b_sel),
    .store_data_fwd (store_data_fwd),
    .dec_wen        (dec_wen),
    .hold_fetch     (hold_fetch),
    .insert_bubble  (insert_bubble)
);

// File: tb/tb_hazard_ctrl.sv
module tb_hazard_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 20;

    typedef struct packed {
        logic [7:0]  tag;
        logic [2:0]  kind;
        logic [31:0] instr;
        logic [4:0]  ex_sa;
        logic [4:0]  ex_sb;
        logic [4:0]  ex_d;
        logic        ex_wen;
        logic        ex_ld;
        logic [4:0]  mem_d;
        logic        mem_wen;
        logic        mem_ld;
        logic        mem_st;
        logic [4:0]  mem_sb;
        logic [4:0]  wb_d;
        logic        wb_wen;
        logic        wb_ld;
        logic [1:0]  fa;
        logic [1:0]  fb;
        logic        stf;
        logic        ba;
        logic        bb;
        logic        stall;
        logic [4:0]  dd;
        logic        dw;
    } vec_t;

    function automatic logic [31:0] ins(int rs, int rt, int rd);
        return {6'd0, 5'(rs), 5'(rt), 5'(rd), 11'd0};
    endfunction

    function automatic vec_t mkv(int tag, int kind, logic [31:0] instr,
                                 int ex_sa, int ex_sb, int ex_d, int ex_wen, int ex_ld,
                                 int mem_d, int mem_wen, int mem_ld, int mem_st, int mem_sb,
                                 int wb_d, int wb_wen, int wb_ld,
                                 int fa, int fb, int stf, int ba, int bb, int stall,
                                 int dd, int dw);
        vec_t v;
        v.tag = 8'(tag);     v.kind = 3'(kind);   v.instr = instr;
        v.ex_sa = 5'(ex_sa); v.ex_sb = 5'(ex_sb); v.ex_d = 5'(ex_d);
        v.ex_wen = 1'(ex_wen); v.ex_ld = 1'(ex_ld);
        v.mem_d = 5'(mem_d); v.mem_wen = 1'(mem_wen); v.mem_ld = 1'(mem_ld);
        v.mem_st = 1'(mem_st); v.mem_sb = 5'(mem_sb);
        v.wb_d = 5'(wb_d);   v.wb_wen = 1'(wb_wen); v.wb_ld = 1'(wb_ld);
        v.fa = 2'(fa);       v.fb = 2'(fb);       v.stf = 1'(stf);
        v.ba = 1'(ba);       v.bb = 1'(bb);       v.stall = 1'(stall);
        v.dd = 5'(dd);       v.dw = 1'(dw);
        return v;
    endfunction

    //            tag kind instr          exA exB exD w l  mD w l s sb  wD w l  fa fb sf ba bb st dd dw
    localparam vec_t VECS [NVEC] = '{
        mkv(2,  0, ins(0,0,0),      1, 2, 0, 0,0,  1,1,0,0,0,   0,0,0,  1, 0, 0,0,0,0,  0,0), // R2 EX/MEM to A
        mkv(3,  0, ins(0,0,0),      3, 4, 0, 0,0,  9,1,0,0,0,   4,1,0,  0, 2, 0,0,0,0,  0,0), // R3 MEM/WB to B
        mkv(4,  0, ins(0,0,0),      5, 5, 0, 0,0,  5,1,0,0,0,   5,1,0,  1, 1, 0,0,0,0,  0,0), // R4 younger wins
        mkv(5,  1, ins(0,0,7),      0, 0, 0, 1,1,  0,1,0,0,0,   0,1,0,  0, 0, 0,0,0,0,  7,1), // R5 register 0
        mkv(6,  4, ins(8,9,3),      6, 7, 0, 0,0,  6,0,0,0,0,   7,0,0,  0, 0, 0,0,0,0,  0,0), // R6 no write enable
        mkv(7,  0, ins(0,0,0),      8, 2, 0, 0,0,  8,1,1,0,0,   8,1,0,  2, 0, 0,0,0,0,  0,0), // R7 load in EX/MEM
        mkv(8,  1, ins(10,11,12),   0, 0,11, 1,1,  0,0,0,0,0,   0,0,0,  0, 0, 0,0,0,1, 12,1), // R8 B load-use
        mkv(8,  2, ins(10,11,0),    0, 0,11, 1,1,  0,0,0,0,0,   0,0,0,  0, 0, 0,0,0,0, 11,1), // R8 R1 RI dest not a source
        mkv(8,  3, ins(13,14,0),    0, 0,13, 1,1,  0,0,0,0,0,   0,0,0,  0, 0, 0,0,0,1, 14,1), // R8 R1 load base
        mkv(8,  1, ins(15,16,1),    0, 0,16, 1,0,  0,0,0,0,0,   0,0,0,  0, 0, 0,0,0,0,  1,1), // R8 ALU producer no stall
        mkv(9,  4, ins(17,18,0),    0, 0,18, 1,1,  0,0,0,0,0,   0,0,0,  0, 0, 0,0,0,0,  0,0), // R9 store data no stall
        mkv(9,  4, ins(18,17,0),    0, 0,18, 1,1,  0,0,0,0,0,   0,0,0,  0, 0, 0,0,0,1,  0,0), // R9 store base stalls
        mkv(10, 0, ins(0,0,0),      0, 0, 0, 0,0,  0,0,0,1,19, 19,1,1,  0, 0, 1,0,0,0,  0,0), // R10 load to store
        mkv(10, 0, ins(0,0,0),      0, 0, 0, 0,0,  0,0,0,1,19, 19,1,0,  0, 0, 0,0,0,0,  0,0), // R10 ALU producer
        mkv(11, 1, ins(20,21,2),    0, 0, 0, 0,0,  0,0,0,0,0,  21,1,0,  0, 0, 0,0,1,0,  2,1), // R11 bypass B
        mkv(11, 2, ins(22,21,0),    0, 0, 0, 0,0,  0,0,0,0,0,  21,1,0,  0, 0, 0,0,0,0, 21,1), // R11 RI no B read
        mkv(11, 4, ins(23,24,0),    0, 0, 0, 0,0,  0,0,0,0,0,  23,1,0,  0, 0, 0,1,0,0,  0,0), // R11 store base bypass
        mkv(1,  6, ins(1,2,3),      0, 0, 0, 0,0,  0,0,0,0,0,   0,0,0,  0, 0, 0,0,0,0,  0,0), // R1 unused code
        mkv(1,  5, ins(25,26,27),   0, 0,26, 1,1,  0,0,0,0,0,   0,0,0,  0, 0, 0,0,0,1,  0,0), // R1 R8 branch uses B
        mkv(3,  0, ins(0,0,0),     30,31, 0, 0,0,  0,0,0,0,0,  31,1,1,  0, 2, 0,0,0,0,  0,0)  // R3 load in MEM/WB
    };

    logic        clk = 1'b0;
    logic [31:0] dec_instr;
    logic [2:0]  dec_kind;
    logic [4:0]  ex_src_a, ex_src_b, ex_dst, mem_dst, mem_store_src, wb_dst;
    logic        ex_wen, ex_load, mem_wen, mem_load, mem_store, wb_wen, wb_load;
    logic [1:0]  fwd_a_sel, fwd_b_sel;
    logic        store_data_fwd, dec_rf_byp_a, dec_rf_byp_b, dec_wen;
    logic [4:0]  dec_dst;
    logic        hold_fetch, insert_bubble;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hazard_ctrl dut (
        .dec_instr      (dec_instr),
        .dec_kind       (dec_kind),
        .ex_src_a       (ex_src_a),
        .ex_src_b       (ex_src_b),
        .ex_dst         (ex_dst),
        .ex_wen         (ex_wen),
        .ex_load        (ex_load),
        .mem_dst        (mem_dst),
        .mem_wen        (mem_wen),
        .mem_load       (mem_load),
        .mem_store      (mem_store),
        .mem_store_src  (mem_store_src),
        .wb_dst         (wb_dst),
        .wb_wen         (wb_wen),
        .wb_load        (wb_load),
        .fwd_a_sel      (fwd_a_sel),
        .fwd_b_sel      (fwd_b_sel),
        .store_data_fwd (store_data_fwd),
        .dec_rf_byp_a   (dec_rf_byp_a),
        .dec_rf_byp_b   (dec_rf_byp_b),
        .dec_dst        (dec_dst),
        .dec_wen        (dec_wen),
        .hold_fetch     (hold_fetch),
        .insert_bubble  (insert_bubble)
    );

    task automatic drive(vec_t v);
        dec_instr = v.instr;   dec_kind = v.kind;
        ex_src_a = v.ex_sa;    ex_src_b = v.ex_sb;   ex_dst = v.ex_d;
        ex_wen = v.ex_wen;     ex_load = v.ex_ld;
        mem_dst = v.mem_d;     mem_wen = v.mem_wen;  mem_load = v.mem_ld;
        mem_store = v.mem_st;  mem_store_src = v.mem_sb;
        wb_dst = v.wb_d;       wb_wen = v.wb_wen;    wb_load = v.wb_ld;
    endtask

    // Outputs packed in one bundle; stall expectation drives both hold and bubble
    task automatic check(vec_t v, int idx);
        logic [15:0] got, exp;
        got = {fwd_a_sel, fwd_b_sel, store_data_fwd, dec_rf_byp_a, dec_rf_byp_b,
               hold_fetch, insert_bubble, dec_dst, dec_wen};
        exp = {v.fa, v.fb, v.stf, v.ba, v.bb, v.stall, v.stall, v.dd, v.dw};
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL R%0d vector %0d: actual %h expected %h", v.tag, idx, got, exp);
        end
    endtask

    initial begin
        drive('0);
        // Idle state with all pipeline registers empty: everything deasserted (R1 R5)
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1 check(mkv(1, 0, 32'd0, 0,0,0,0,0, 0,0,0,0,0, 0,0,0, 0,0,0,0,0,0, 0,0), -1);

        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            drive(VECS[i]);
            #1 check(VECS[i], i);
        end

        // Corner: register 0 load in ID/EX against a decode that reads register 0 (R5)
        @(negedge clk);
        drive(mkv(5, 1, ins(0,0,3), 0,0,0,1,1, 0,1,0,1,0, 0,1,1, 0,0,0,0,0,0, 3,1));
        #1 check(mkv(5, 1, ins(0,0,3), 0,0,0,1,1, 0,1,0,1,0, 0,1,1, 0,0,0,0,0,0, 3,1), 100);

        // Corner: kind code 7 behaves as no instruction despite a matching load (R1 R8)
        @(negedge clk);
        drive(mkv(1, 7, ins(4,4,4), 0,0,4,1,1, 0,0,0,0,0, 4,1,0, 0,0,0,0,0,0, 0,0));
        #1 check(mkv(1, 7, ins(4,4,4), 0,0,4,1,1, 0,0,0,0,0, 4,1,0, 0,0,0,0,0,0, 0,0), 101);

        // Back to idle after the sequence (R2 R3)
        @(negedge clk);
        drive('0);
        #1 check(mkv(2, 0, 32'd0, 0,0,0,0,0, 0,0,0,0,0, 0,0,0, 0,0,0,0,0,0, 0,0), 102);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule